// File: doc/BRIEF.md
# Cipher Output Stream Formatter

This block assembles the outbound word stream of an authenticated cipher core. It has a 32-bit valid/ready output. A job starts with a command that gives the direction and the message byte count. The formatter then frames the processed data words it receives. Each data segment is preceded by a self-describing header word that carries the segment type, flag bits and byte length.

An encryption job emits four things in order: a ciphertext header, the ciphertext words, a tag header and the tag words. A decryption job emits a plaintext header, then the plaintext words, then a single status word that reports whether verification passed. Plaintext is released as soon as it arrives, with no wait for the verification result. The nonce and associated data never reach the output. Cipher arithmetic and any holding of released plaintext are handled elsewhere.

One output register sits between the formatter and the consumer. When the consumer stops accepting words, that register holds its word and the formatter withdraws its ready signals on every upstream port.

Top module: `aead_ofmt`

## Requirements
- R1: After reset `do_valid` is low and `cmd_ready` is high.
- R2: A segment header word has these fields: bits [31:28] hold the segment type, bit 27 is Partial (always 0 here), bit 26 is EOI, bit 25 is EOT, bit 24 is Last, bits [23:16] are zero, and bits [15:0] hold the segment byte length. A data segment header has EOT=1, Last=0, EOI=1 exactly when its length is nonzero, and the length equal to `cmd_len`.
- R3: An encryption job outputs, in order: a header of type 4'b0101, ceil(len/4) ciphertext words, a tag header, and TAG_WORDS tag words passed through unchanged. The tag header has type 4'b1000, EOI=0, EOT=1, Last=1 and length 4*TAG_WORDS.
- R4: A decryption job outputs, in order: a header of type 4'b0100 with Last=0, ceil(len/4) plaintext words, and then exactly one status word.
- R5: The status word is 32'hE000_0000 when `vfy_pass` is 1 and 32'hF000_0000 when it is 0.
- R6: When `cmd_len` is 0, a header with length field 0 is still emitted and `din_ready` never rises during the job.
- R7: The first message byte of a word sits in bits [31:24]. On the word marked `din_last`, the byte lanes beyond `cmd_len` mod 4 are output as zero when that remainder is nonzero.
- R8: A word moves only when valid and ready are both high. While `do_valid` is high and `do_ready` is low, `do_data` holds its value and `din_ready`, `tag_ready` and `vfy_ready` are all low.
- R9: In a decryption job, all plaintext words are delivered on the output before `vfy_valid` is ever asserted.
- R10: `cmd_ready` is low from the cycle after a command is accepted until the job's final word has been taken from its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Job command offered |
| cmd_ready | output | 1 | Formatter idle, command taken |
| cmd_decrypt | input | 1 | 1 = decryption job, 0 = encryption job |
| cmd_len | input | 16 | Message byte count |
| din_valid | input | 1 | Processed data word offered |
| din_ready | output | 1 | Data word taken |
| din_data | input | 32 | Data word, first byte in bits [31:24] |
| din_last | input | 1 | Marks the final data word |
| tag_valid | input | 1 | Tag word offered |
| tag_ready | output | 1 | Tag word taken |
| tag_data | input | 32 | Tag word |
| vfy_valid | input | 1 | Verification result offered |
| vfy_ready | output | 1 | Verification result taken |
| vfy_pass | input | 1 | 1 = tag matched |
| do_valid | output | 1 | Output word present |
| do_ready | input | 1 | Consumer takes output word |
| do_data | output | 32 | Output word |

## Verification
Every message length from 0 to 9 bytes is run in both directions. This covers the empty message, every tail remainder from 0 to 3, and one, two and three data words. Each length and direction is run twice: once with the consumer always ready and once with a pseudo-random stall pattern. Comparing the two runs separates framing errors from handshake errors. The data words are driven with every byte lane filled, so a missing tail clear shows up as a nonzero byte. Decryption jobs alternate between pass and fail, and the verification result is withheld until all plaintext has been seen. A design that buffered plaintext behind the verdict would therefore stall and be reported.

// File: rtl/aead_ofmt_pkg.sv
package aead_ofmt_pkg;

  localparam int WORD_W = 32;
  localparam int LEN_W  = 16;

  typedef enum logic [3:0] {
    SEG_PT  = 4'b0100,
    SEG_CT  = 4'b0101,
    SEG_TAG = 4'b1000
  } seg_type_e;

  localparam logic [3:0] STAT_OK  = 4'b1110;
  localparam logic [3:0] STAT_BAD = 4'b1111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_TAGH,
    ST_TAG,
    ST_STAT
  } fmt_state_e;

  typedef struct packed {
    seg_type_e         kind;
    logic              partial;
    logic              eoi;
    logic              eot;
    logic              last;
    logic [7:0]        rsvd;
    logic [LEN_W-1:0]  len;
  } seg_hdr_t;

endpackage

// File: rtl/ofmt_hdr_pack.sv
module ofmt_hdr_pack
  import aead_ofmt_pkg::*;
(
  input  seg_type_e          kind,
  input  logic               eoi,
  input  logic               eot,
  input  logic               last,
  input  logic [LEN_W-1:0]   len,
  output logic [WORD_W-1:0]  word
);

  seg_hdr_t hdr;

  always_comb begin
    hdr.kind    = kind;
    hdr.partial = 1'b0;
    hdr.eoi     = eoi;
    hdr.eot     = eot;
    hdr.last    = last;
    hdr.rsvd    = 8'h00;
    hdr.len     = len;
    word        = hdr;
  end

endmodule

// File: rtl/ofmt_lane_mask.sv
module ofmt_lane_mask #(
  parameter int BYTES = 4,
  localparam int REM_W = $clog2(BYTES)
) (
  input  logic [BYTES*8-1:0] din,
  input  logic               tail,
  input  logic [REM_W-1:0]   rem,
  output logic [BYTES*8-1:0] dout
);

  // lane 0 is the most significant byte (first byte of the word)
  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    logic keep;
    assign keep = !tail || (rem == '0) || (32'(i) < 32'(rem));
    assign dout[(BYTES-1-i)*8 +: 8] = keep ? din[(BYTES-1-i)*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/aead_ofmt.sv
module aead_ofmt
  import aead_ofmt_pkg::*;
#(
  parameter int TAG_WORDS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_decrypt,
  input  logic [15:0]        cmd_len,
  input  logic               din_valid,
  output logic               din_ready,
  input  logic [31:0]        din_data,
  input  logic               din_last,
  input  logic               tag_valid,
  output logic               tag_ready,
  input  logic [31:0]        tag_data,
  input  logic               vfy_valid,
  output logic               vfy_ready,
  input  logic               vfy_pass,
  output logic               do_valid,
  input  logic               do_ready,
  output logic [31:0]        do_data
);

  localparam int BYTES = WORD_W / 8;
  localparam int REM_W = $clog2(BYTES);
  localparam int CNT_W = $clog2(TAG_WORDS + 1);
  localparam logic [LEN_W-1:0] TAG_LEN = LEN_W'(TAG_WORDS * BYTES);

  fmt_state_e         st_q, st_d;
  logic               dec_q, dec_d;
  logic [LEN_W-1:0]   len_q, len_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               load;
  logic [WORD_W-1:0]  word_d;
  logic               slot_free;

  seg_type_e          data_kind;
  logic [WORD_W-1:0]  data_hdr_w, tag_hdr_w, masked_w;

  assign slot_free = !do_valid || do_ready;
  assign cmd_ready = (st_q == ST_IDLE);
  assign din_ready = (st_q == ST_DATA) && slot_free;
  assign tag_ready = (st_q == ST_TAG)  && slot_free;
  assign vfy_ready = (st_q == ST_STAT) && slot_free;

  always_comb begin
    if (dec_q) data_kind = SEG_PT;
    else       data_kind = SEG_CT;
  end

  ofmt_hdr_pack u_data_hdr (
    .kind (data_kind),
    .eoi  (len_q != '0),
    .eot  (1'b1),
    .last (1'b0),
    .len  (len_q),
    .word (data_hdr_w)
  );

  ofmt_hdr_pack u_tag_hdr (
    .kind (SEG_TAG),
    .eoi  (1'b0),
    .eot  (1'b1),
    .last (1'b1),
    .len  (TAG_LEN),
    .word (tag_hdr_w)
  );

  ofmt_lane_mask #(.BYTES(BYTES)) u_mask (
    .din  (din_data),
    .tail (din_last),
    .rem  (len_q[REM_W-1:0]),
    .dout (masked_w)
  );

  // next-state logic
  always_comb begin
    st_d   = st_q;
    dec_d  = dec_q;
    len_d  = len_q;
    cnt_d  = cnt_q;
    load   = 1'b0;
    word_d = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          dec_d = cmd_decrypt;
          len_d = cmd_len;
          st_d  = ST_HDR;
        end
      end
      ST_HDR: begin
        if (slot_free) begin
          load   = 1'b1;
          word_d = data_hdr_w;
          if (len_q != '0)  st_d = ST_DATA;
          else if (dec_q)   st_d = ST_STAT;
          else              st_d = ST_TAGH;
        end
      end
      ST_DATA: begin
        if (slot_free && din_valid) begin
          load   = 1'b1;
          word_d = masked_w;
          if (din_last) st_d = dec_q ? ST_STAT : ST_TAGH;
        end
      end
      ST_TAGH: begin
        if (slot_free) begin
          load   = 1'b1;
          word_d = tag_hdr_w;
          cnt_d  = '0;
          st_d   = ST_TAG;
        end
      end
      ST_TAG: begin
        if (slot_free && tag_valid) begin
          load   = 1'b1;
          word_d = tag_data;
          if (cnt_q == CNT_W'(TAG_WORDS - 1)) st_d = ST_IDLE;
          else cnt_d = cnt_q + 1'b1;
        end
      end
      ST_STAT: begin
        if (slot_free && vfy_valid) begin
          load   = 1'b1;
          word_d = {(vfy_pass ? STAT_OK : STAT_BAD), {(WORD_W-4){1'b0}}};
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      dec_q <= 1'b0;
      len_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      dec_q <= dec_d;
      len_q <= len_d;
      cnt_q <= cnt_d;
    end
  end

  // output register with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      do_valid <= 1'b0;
      do_data  <= '0;
    end else begin
      if (load) begin
        do_valid <= 1'b1;
        do_data  <= word_d;
      end else if (do_ready) begin
        do_valid <= 1'b0;
      end
    end
  end

  // R8: a stalled word stays put
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (do_valid && !do_ready) |=> (do_valid && $stable(do_data)));

  // R8: no upstream pull while the output is blocked
  a_r8_no_pull: assert property (@(posedge clk) disable iff (!rst_n)
    (do_valid && !do_ready) |-> (!din_ready && !tag_ready && !vfy_ready));

  // R5: status word coding
  a_r5_status_code: assert property (@(posedge clk) disable iff (!rst_n)
    (vfy_valid && vfy_ready) |=>
      (do_valid && do_data[31:28] == ($past(vfy_pass) ? 4'hE : 4'hF)
       && do_data[27:0] == 28'h0));

  // R3: tag words forwarded unchanged
  a_r3_tag_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && tag_ready) |=> (do_valid && do_data == $past(tag_data)));

  // R7: one-byte tail clears the three low lanes
  a_r7_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid && din_ready && din_last && len_q[1:0] == 2'd1) |=>
      (do_data[23:0] == 24'h0));

endmodule

// File: tb/aead_ofmt_bench.sv
module aead_ofmt_bench;

  localparam int TW = 4;

  logic        clk, rst_n;
  logic        cmd_valid, cmd_ready, cmd_decrypt;
  logic [15:0] cmd_len;
  logic        din_valid, din_ready, din_last;
  logic [31:0] din_data;
  logic        tag_valid, tag_ready;
  logic [31:0] tag_data;
  logic        vfy_valid, vfy_ready, vfy_pass;
  logic        do_valid, do_ready;
  logic [31:0] do_data;

  int errs = 0;
  int checks = 0;
  logic [31:0] got[$];
  int stall_mode = 0;
  logic [7:0] lfsr = 8'h5B;
  bit prev_stall = 0;
  logic [31:0] prev_word = '0;
  bit saw_din_ready = 0;

  aead_ofmt #(.TAG_WORDS(TW)) u_aead_ofmt (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_decrypt(cmd_decrypt), .cmd_len(cmd_len),
    .din_valid(din_valid), .din_ready(din_ready),
    .din_data(din_data), .din_last(din_last),
    .tag_valid(tag_valid), .tag_ready(tag_ready), .tag_data(tag_data),
    .vfy_valid(vfy_valid), .vfy_ready(vfy_ready), .vfy_pass(vfy_pass),
    .do_valid(do_valid), .do_ready(do_ready), .do_data(do_data)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // sink: sets ready at the falling edge, then records what will transfer
  always @(negedge clk) begin
    if (!rst_n) begin
      do_ready = 1'b0;
      prev_stall = 0;
    end else begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      do_ready = (stall_mode == 0) ? 1'b1 : lfsr[0];
      #1;
      if (prev_stall)
        chk(do_valid && do_data == prev_word, "R8 hold", do_data, prev_word);
      if (do_valid && !do_ready)
        chk(!din_ready && !tag_ready && !vfy_ready, "R8 pull",
            {29'h0, din_ready, tag_ready, vfy_ready}, 32'h0);
      if (din_ready) saw_din_ready = 1;
      if (do_valid && do_ready) got.push_back(do_data);
      prev_stall = do_valid && !do_ready;
      prev_word  = do_data;
    end
  end

  function automatic logic [7:0] msg_byte(int len, int k);
    return 8'((len * 13 + k * 7 + 1) | 8'h80);
  endfunction

  task automatic run_job(bit dec, int len, bit pass, int id);
    logic [31:0] exp[$];
    int nw = (len + 3) / 4;
    int waitc;
    string tg;
    exp.push_back({dec ? 4'b0100 : 4'b0101, 1'b0, (len != 0), 1'b1, 1'b0, 8'h00, 16'(len)});
    for (int j = 0; j < nw; j++) begin
      logic [31:0] w;
      for (int b = 0; b < 4; b++)
        w[31-8*b -: 8] = (4*j + b < len) ? msg_byte(len, 4*j + b) : 8'h00;
      exp.push_back(w);
    end
    if (dec) exp.push_back({pass ? 4'hE : 4'hF, 28'h0});
    else begin
      exp.push_back({4'b1000, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 16'(TW*4)});
      for (int i = 0; i < TW; i++) exp.push_back(32'hA500_0000 + 32'(id*16 + i));
    end
    got.delete();
    saw_din_ready = 0;

    @(negedge clk); #2;
    cmd_valid = 1; cmd_decrypt = dec; cmd_len = 16'(len);
    while (!cmd_ready) begin @(negedge clk); #2; end
    @(negedge clk); #2;
    cmd_valid = 0;
    chk(!cmd_ready, "R10", {31'h0, cmd_ready}, 32'h0);

    fork
      begin
        for (int j = 0; j < nw; j++) begin
          din_valid = 1; din_last = (j == nw - 1);
          for (int b = 0; b < 4; b++) din_data[31-8*b -: 8] = msg_byte(len, 4*j + b);
          while (!din_ready) begin @(negedge clk); #2; end
          @(posedge clk); @(negedge clk); #2;
          din_valid = 0; din_last = 0;
        end
      end
      begin
        if (!dec) begin
          for (int i = 0; i < TW; i++) begin
            tag_valid = 1; tag_data = 32'hA500_0000 + 32'(id*16 + i);
            while (!tag_ready) begin @(negedge clk); #2; end
            @(posedge clk); @(negedge clk); #2;
            tag_valid = 0;
          end
        end
      end
      begin
        if (dec) begin
          waitc = 0;
          while (got.size() < 1 + nw && waitc < 300) begin @(negedge clk); #2; waitc++; end
          chk(got.size() >= 1 + nw, "R9", 32'(got.size()), 32'(1 + nw));
          vfy_valid = 1; vfy_pass = pass;
          waitc = 0;
          while (!vfy_ready && waitc < 300) begin @(negedge clk); #2; waitc++; end
          @(posedge clk); @(negedge clk); #2;
          vfy_valid = 0;
        end
      end
    join

    waitc = 0;
    while (got.size() < exp.size() && waitc < 300) begin @(negedge clk); #2; waitc++; end
    repeat (4) @(negedge clk);
    #2;
    chk(got.size() == exp.size(), dec ? "R4 count" : "R3 count",
        32'(got.size()), 32'(exp.size()));
    if (len == 0) chk(!saw_din_ready, "R6 no data pull", {31'h0, saw_din_ready}, 32'h0);
    for (int k = 0; k < exp.size() && k < got.size(); k++) begin
      if (k == 0)                      tg = (len == 0) ? "R6 header" : "R2 header";
      else if (k == nw && nw > 0)      tg = "R7 tail word";
      else if (k < nw)                 tg = dec ? "R4 data" : "R3 data";
      else if (dec)                    tg = "R5 status";
      else                             tg = "R3 tag";
      chk(got[k] === exp[k], tg, got[k], exp[k]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 0;
    cmd_valid = 0; cmd_decrypt = 0; cmd_len = '0;
    din_valid = 0; din_data = '0; din_last = 0;
    tag_valid = 0; tag_data = '0;
    vfy_valid = 0; vfy_pass = 0;
    repeat (3) @(negedge clk);
    #2;
    chk(!do_valid, "R1 valid", {31'h0, do_valid}, 32'h0);
    chk(cmd_ready, "R1 ready", {31'h0, cmd_ready}, 32'h1);
    rst_n = 1;
    @(negedge clk); #2;
    chk(!do_valid && cmd_ready, "R1 after release", {30'h0, do_valid, cmd_ready}, 32'h1);
    for (int s = 0; s < 2; s++) begin
      stall_mode = s;
      for (int len = 0; len < 10; len++)
        for (int d = 0; d < 2; d++)
          run_job(d[0], len, (len % 2) == 0, s*20 + len*2 + d);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule